// File: doc/BRIEF.md
# HDLC Receive FIFO Drain Controller

This block sits behind an HDLC receiver that already does the bit-level work (flag detection, zero-bit removal and CRC checking) and presents received bytes through a 32-byte FIFO window. Two events drive the block. A pool-full event means the window holds a full chunk. A message-end event means a frame has closed; it comes with the receiver's status byte and the residual byte count of the last chunk. The block copies each chunk into a local frame buffer, one byte per cycle, and returns the window to the receiver with a one-cycle release strobe after each chunk.

At message end the block decides whether to accept the frame. The decision uses a few packed status bits. A frame that fails the check is dropped and its window is released. If a chunk would push the buffer to its length limit, the whole frame in progress is thrown away. An accepted frame of non-zero length leaves the block as a byte stream with valid and last markers and a length field.

The parameter `HAS_TRAILER` selects a second variant. In this variant a valid-frame bit must also be set, the receiver appends one status byte that is not delivered, and a separate receive-overflow event only releases the window.

Top module: `rxd_drain`

## Requirements
- R1: Each pool-full event that fits in the buffer produces exactly 32 consecutive `fifoRd` cycles, then one `relCmd` cycle.
- R2: At message end the chunk size is `resCount`, and a value of 0 reads 32 bytes. The reads are followed by one `relCmd` cycle.
- R3: With `HAS_TRAILER`=0, a frame is accepted only when `statusIn` bit 5 (CRC good) is 1 and bits 6 (overflow) and 4 (abort) are 0. The other status bits are ignored. A rejected frame gets no reads and no output, and gets one release. The bytes it had buffered never appear in a later frame.
- R4: With `HAS_TRAILER`=1, status bit 7 (valid frame) must also be 1. The last buffered byte is removed: the delivered length is the byte count minus 1.
- R5: There is exactly one `relCmd` pulse per serviced pool-full, message-end or (with `HAS_TRAILER`=1) overflow event. `relCmd` is never high together with `fifoRd`.
- R6: If the buffered count plus the new chunk is at least `MAX_LEN`, the chunk is not read. The window is released and the buffer is emptied. A total of `MAX_LEN`-1 still fits.
- R7: A frame whose final length is below 1 is not delivered. The buffer is empty after every message end, whether the frame was accepted or dropped.
- R8: With `HAS_TRAILER`=1, `fifoOvf` causes one release and nothing else, and the buffered bytes are kept. With `HAS_TRAILER`=0, `fifoOvf` has no effect.
- R9: An accepted frame is sent as `outValid` on consecutive cycles, with bytes in arrival order. `outLast` marks the final byte, and `outLen` carries the delivered length while `outValid` is high.
- R10: An event that arrives while the block is busy is held and serviced later. Pending events are served in this order: overflow, then pool-full, then message-end.
- R11: After reset, `fifoRd`, `relCmd`, `outValid` and `outLast` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| poolFull | input | 1 | Pulse: a full 32-byte chunk waits in the window |
| msgEnd | input | 1 | Pulse: frame closed; `statusIn` and `resCount` are valid in this cycle |
| fifoOvf | input | 1 | Pulse: receive overflow (acted on only with `HAS_TRAILER`=1) |
| statusIn | input | 8 | Receive status byte, sampled with `msgEnd` |
| resCount | input | 5 | Low bits of the receive byte count, sampled with `msgEnd` |
| fifoData | input | 8 | Head byte of the FIFO window |
| fifoRd | output | 1 | Pop one byte from the window this cycle |
| relCmd | output | 1 | One-cycle release of the window to the receiver |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Output byte |
| outLast | output | 1 | Final byte of the frame |
| outLen | output | 9 | Delivered frame length while `outValid` is high, else 0 |

## Verification
A buffer index that is not cleared correctly shows up on the next delivered frame: it carries stale leading bytes and its `outLen` is too large. This appears as soon as that frame is streamed, which can be several events later. A wrong acceptance decision or overrun decision shows up within about forty cycles of the event. The symptom is that `fifoRd` pulses are missing or extra, or a frame appears on the output when none was expected. Lost pending events or a wrong priority among them change the byte order or the length of the next frame. Running the frames through a scoreboard therefore catches them.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFull;   // arm a full-window chunk
    logic loadEnd;    // arm a residual chunk
    logic readByte;   // store one window byte
    logic clearIdx;   // empty the frame buffer
    logic emitStep;   // send one buffered byte
  } dpCmd_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_READ,
    S_REL,
    S_EMIT
  } ctrlState_t;

  typedef enum logic [1:0] {
    J_FULL,
    J_END,
    J_DROP,
    J_OVF
  } job_t;

endpackage

// File: rtl/rxd_datapath.sv
module rxd_datapath
  import rxd_pkg::*;
#(
  parameter int MAX_LEN     = 300,
  parameter int WIN_BYTES   = 32,
  parameter bit HAS_TRAILER = 1'b0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpCmd_t                        cmd,
  input  logic                          msgEnd,
  input  logic [7:0]                    statusIn,
  input  logic [$clog2(WIN_BYTES)-1:0]  resCount,
  input  logic [7:0]                    fifoData,
  output logic                          frameOk,
  output logic                          fitFull,
  output logic                          fitEnd,
  output logic                          lastRead,
  output logic                          lenOk,
  output logic                          lastEmit,
  output logic                          outValid,
  output logic [7:0]                    outData,
  output logic                          outLast,
  output logic [$clog2(MAX_LEN+1)-1:0]  outLen
);

  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int CNT_W = $clog2(WIN_BYTES);
  localparam int REM_W = $clog2(WIN_BYTES + 1);
  localparam int SUM_W = LEN_W + REM_W;
  localparam int STRIP = HAS_TRAILER ? 1 : 0;
  localparam logic [7:0] ACC_MASK = HAS_TRAILER ? 8'hF0 : 8'h70;
  localparam logic [7:0] ACC_VAL  = HAS_TRAILER ? 8'hA0 : 8'h20;

  logic [7:0]       mem [MAX_LEN];
  logic [LEN_W-1:0] idx;
  logic [LEN_W-1:0] ptr;
  logic [REM_W-1:0] remain;
  logic [7:0]       capStatus;
  logic [CNT_W-1:0] capRes;
  logic [REM_W-1:0] resBytes;
  logic [LEN_W-1:0] finalLen;

  // status and residual count are captured with the message-end pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capStatus <= '0;
      capRes    <= '0;
    end else if (msgEnd) begin
      capStatus <= statusIn;
      capRes    <= resCount;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx <= '0;
    end else if (cmd.clearIdx) begin
      idx <= '0;
    end else if (cmd.readByte) begin
      idx <= idx + LEN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
    end else if (cmd.loadFull) begin
      remain <= REM_W'(WIN_BYTES);
    end else if (cmd.loadEnd) begin
      remain <= resBytes;
    end else if (cmd.readByte) begin
      remain <= remain - REM_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (cmd.readByte) begin
      mem[idx] <= fifoData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (cmd.clearIdx) begin
      ptr <= '0;
    end else if (cmd.emitStep) begin
      ptr <= ptr + LEN_W'(1);
    end
  end

  always_comb begin
    resBytes = (capRes == '0) ? REM_W'(WIN_BYTES) : REM_W'(capRes);
    finalLen = idx - LEN_W'(STRIP);
    frameOk  = (capStatus & ACC_MASK) == ACC_VAL;
    fitFull  = (SUM_W'(idx) + SUM_W'(WIN_BYTES)) < SUM_W'(MAX_LEN);
    fitEnd   = (SUM_W'(idx) + SUM_W'(resBytes)) < SUM_W'(MAX_LEN);
    lastRead = remain == REM_W'(1);
    lenOk    = idx > LEN_W'(STRIP);
    lastEmit = ptr == (finalLen - LEN_W'(1));
    outValid = cmd.emitStep;
    outData  = cmd.emitStep ? mem[ptr] : 8'h00;
    outLast  = cmd.emitStep & lastEmit;
    outLen   = cmd.emitStep ? finalLen : '0;
  end

  a_r6_idx_bound: assert property (@(posedge clk) disable iff (!rstN)
    idx < LEN_W'(MAX_LEN));
  a_r9_last_valid: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);
  a_r9_len_pos: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outLen != '0));
  a_r7_clear_after_frame: assert property (@(posedge clk) disable iff (!rstN)
    outLast |=> (idx == '0));

endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
  import rxd_pkg::*;
#(
  parameter bit HAS_TRAILER = 1'b0
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   poolFull,
  input  logic   msgEnd,
  input  logic   fifoOvf,
  input  logic   frameOk,
  input  logic   fitFull,
  input  logic   fitEnd,
  input  logic   lastRead,
  input  logic   lenOk,
  input  logic   lastEmit,
  output dpCmd_t cmd,
  output logic   fifoRd,
  output logic   relCmd
);

  ctrlState_t state, stateNext;
  job_t       job, jobNext;
  logic       fullP, endP, ovfP;
  logic       takeFull, takeEnd, takeOvf;

  // held events; a new pulse wins over a same-cycle clear (R10)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fullP <= 1'b0;
      endP  <= 1'b0;
      ovfP  <= 1'b0;
    end else begin
      fullP <= (fullP & ~takeFull) | poolFull;
      endP  <= (endP & ~takeEnd) | msgEnd;
      ovfP  <= (ovfP & ~takeOvf) | (fifoOvf & HAS_TRAILER);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      job   <= J_FULL;
    end else begin
      state <= stateNext;
      job   <= jobNext;
    end
  end

  always_comb begin
    cmd       = '0;
    stateNext = state;
    jobNext   = job;
    takeFull  = 1'b0;
    takeEnd   = 1'b0;
    takeOvf   = 1'b0;
    fifoRd    = 1'b0;
    relCmd    = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (ovfP) begin
          takeOvf   = 1'b1;
          jobNext   = J_OVF;
          stateNext = S_REL;
        end else if (fullP) begin
          takeFull = 1'b1;
          jobNext  = J_FULL;
          if (fitFull) begin
            cmd.loadFull = 1'b1;
            stateNext    = S_READ;
          end else begin
            cmd.clearIdx = 1'b1;
            stateNext    = S_REL;
          end
        end else if (endP) begin
          takeEnd = 1'b1;
          if (!frameOk) begin
            jobNext   = J_DROP;
            stateNext = S_REL;
          end else if (fitEnd) begin
            jobNext     = J_END;
            cmd.loadEnd = 1'b1;
            stateNext   = S_READ;
          end else begin
            jobNext      = J_END;
            cmd.clearIdx = 1'b1;
            stateNext    = S_REL;
          end
        end
      end
      S_READ: begin
        fifoRd       = 1'b1;
        cmd.readByte = 1'b1;
        if (lastRead) stateNext = S_REL;
      end
      S_REL: begin
        relCmd    = 1'b1;
        stateNext = S_IDLE;
        if (job == J_END) begin
          if (lenOk) stateNext = S_EMIT;
          else cmd.clearIdx = 1'b1;
        end else if (job == J_DROP) begin
          cmd.clearIdx = 1'b1;
        end
      end
      S_EMIT: begin
        cmd.emitStep = 1'b1;
        if (lastEmit) begin
          cmd.clearIdx = 1'b1;
          stateNext    = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  a_r5_read_rel_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoRd && relCmd));
  a_r1_rel_after_read: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fifoRd) |-> relCmd);
  a_r5_single_rel: assert property (@(posedge clk) disable iff (!rstN)
    relCmd |=> !relCmd);

endmodule

// File: rtl/rxd_drain.sv
module rxd_drain
  import rxd_pkg::*;
#(
  parameter int MAX_LEN     = 300,
  parameter int WIN_BYTES   = 32,
  parameter bit HAS_TRAILER = 1'b0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          poolFull,
  input  logic                          msgEnd,
  input  logic                          fifoOvf,
  input  logic [7:0]                    statusIn,
  input  logic [$clog2(WIN_BYTES)-1:0]  resCount,
  input  logic [7:0]                    fifoData,
  output logic                          fifoRd,
  output logic                          relCmd,
  output logic                          outValid,
  output logic [7:0]                    outData,
  output logic                          outLast,
  output logic [$clog2(MAX_LEN+1)-1:0]  outLen
);

  dpCmd_t cmd;
  logic   frameOk, fitFull, fitEnd, lastRead, lenOk, lastEmit;

  rxd_ctrl #(
    .HAS_TRAILER(HAS_TRAILER)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .poolFull (poolFull),
    .msgEnd   (msgEnd),
    .fifoOvf  (fifoOvf),
    .frameOk  (frameOk),
    .fitFull  (fitFull),
    .fitEnd   (fitEnd),
    .lastRead (lastRead),
    .lenOk    (lenOk),
    .lastEmit (lastEmit),
    .cmd      (cmd),
    .fifoRd   (fifoRd),
    .relCmd   (relCmd)
  );

  rxd_datapath #(
    .MAX_LEN    (MAX_LEN),
    .WIN_BYTES  (WIN_BYTES),
    .HAS_TRAILER(HAS_TRAILER)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .msgEnd   (msgEnd),
    .statusIn (statusIn),
    .resCount (resCount),
    .fifoData (fifoData),
    .frameOk  (frameOk),
    .fitFull  (fitFull),
    .fitEnd   (fitEnd),
    .lastRead (lastRead),
    .lenOk    (lenOk),
    .lastEmit (lastEmit),
    .outValid (outValid),
    .outData  (outData),
    .outLast  (outLast),
    .outLen   (outLen)
  );

endmodule

// File: tb/rxd_drain_test.sv
module rxd_drain_test;

  localparam int MAXL = 300;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] poolFull = '0;
  logic [1:0] msgEnd = '0;
  logic [1:0] fifoOvf = '0;
  logic [1:0] fifoRd, relCmd, outValid, outLast;
  logic [7:0] statusIn [2];
  logic [4:0] resCount [2];
  logic [7:0] fifoData [2];
  logic [7:0] outData [2];
  logic [8:0] outLen [2];

  int srcIdx [2];
  int relCnt [2];
  int rdCnt [2];
  int expRel [2];
  int expRd [2];
  int mCur [2];
  int sel = 0;
  int checks = 0;
  int errors = 0;
  logic [7:0] curBuf[$];
  logic [7:0] expBytes[$];
  int expLens[$];
  int frameBytes = 0;
  bit frameBad = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] genByte(input int i);
    return 8'(i * 37 + 5);
  endfunction

  assign fifoData[0] = genByte(srcIdx[0]);
  assign fifoData[1] = genByte(srcIdx[1]);

  rxd_drain #(.MAX_LEN(MAXL), .WIN_BYTES(32), .HAS_TRAILER(1'b0)) uut (
    .clk(clk), .rstN(rstN), .poolFull(poolFull[0]), .msgEnd(msgEnd[0]),
    .fifoOvf(fifoOvf[0]), .statusIn(statusIn[0]), .resCount(resCount[0]),
    .fifoData(fifoData[0]), .fifoRd(fifoRd[0]), .relCmd(relCmd[0]),
    .outValid(outValid[0]), .outData(outData[0]), .outLast(outLast[0]),
    .outLen(outLen[0]));

  rxd_drain #(.MAX_LEN(MAXL), .WIN_BYTES(32), .HAS_TRAILER(1'b1)) uutB (
    .clk(clk), .rstN(rstN), .poolFull(poolFull[1]), .msgEnd(msgEnd[1]),
    .fifoOvf(fifoOvf[1]), .statusIn(statusIn[1]), .resCount(resCount[1]),
    .fifoData(fifoData[1]), .fifoRd(fifoRd[1]), .relCmd(relCmd[1]),
    .outValid(outValid[1]), .outData(outData[1]), .outLast(outLast[1]),
    .outLen(outLen[1]));

  // window source and port counters
  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rstN) begin
        srcIdx[k] <= 0;
        relCnt[k] <= 0;
        rdCnt[k]  <= 0;
      end else begin
        if (fifoRd[k]) begin
          srcIdx[k] <= srcIdx[k] + 1;
          rdCnt[k]  <= rdCnt[k] + 1;
        end
        if (relCmd[k]) relCnt[k] <= relCnt[k] + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // monitor: compare streamed frames against the scoreboard (R9)
  always @(negedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (rstN && outValid[k]) begin : mon
        logic [7:0] b;
        int el;
        if (k != sel || expBytes.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R9 unexpected byte lane %0d act=%0d exp=none", k, outData[k]);
        end else begin
          b = expBytes.pop_front();
          if (b != outData[k]) frameBad = 1'b1;
          frameBytes++;
          if (outLast[k]) begin
            el = (expLens.size() != 0) ? expLens.pop_front() : -1;
            check(!frameBad && frameBytes == el && int'(outLen[k]) == el,
                  "R9 frame content/length", int'(outLen[k]), el);
            frameBytes = 0;
            frameBad = 1'b0;
          end
        end
      end
    end
  end

  task automatic checkCounts(input string tag);
    check(relCnt[sel] == expRel[sel], {tag, " releases"}, relCnt[sel], expRel[sel]);
    check(rdCnt[sel] == expRd[sel], {tag, " reads"}, rdCnt[sel], expRd[sel]);
    check(expBytes.size() == 0, {tag, " frames delivered"}, expBytes.size(), 0);
  endtask

  function automatic void modelFull();
    if (curBuf.size() + 32 >= MAXL) begin
      curBuf.delete();
    end else begin
      for (int i = 0; i < 32; i++) begin
        curBuf.push_back(genByte(mCur[sel]));
        mCur[sel]++;
        expRd[sel]++;
      end
    end
    expRel[sel]++;
  endfunction

  function automatic void modelEnd(input logic [7:0] st, input int res);
    bit ok;
    int n;
    int len;
    ok = sel ? ((st & 8'hF0) == 8'hA0) : ((st & 8'h70) == 8'h20);
    if (!ok) begin
      curBuf.delete();
    end else begin
      n = (res == 0) ? 32 : res;
      if (curBuf.size() + n >= MAXL) begin
        curBuf.delete();
      end else begin
        for (int i = 0; i < n; i++) begin
          curBuf.push_back(genByte(mCur[sel]));
          mCur[sel]++;
          expRd[sel]++;
        end
      end
    end
    len = curBuf.size() - (sel ? 1 : 0);
    if (len >= 1) begin
      for (int i = 0; i < len; i++) expBytes.push_back(curBuf[i]);
      expLens.push_back(len);
    end
    curBuf.delete();
    expRel[sel]++;
  endfunction

  task automatic doFull(input string tag);
    modelFull();
    @(negedge clk);
    poolFull[sel] = 1'b1;
    @(negedge clk);
    poolFull[sel] = 1'b0;
    repeat (40) @(negedge clk);
    check(relCnt[sel] == expRel[sel], {tag, " releases"}, relCnt[sel], expRel[sel]);
    check(rdCnt[sel] == expRd[sel], {tag, " reads"}, rdCnt[sel], expRd[sel]);
  endtask

  task automatic doEnd(input logic [7:0] st, input int res, input string tag);
    modelEnd(st, res);
    @(negedge clk);
    statusIn[sel] = st;
    resCount[sel] = 5'(res);
    msgEnd[sel] = 1'b1;
    @(negedge clk);
    msgEnd[sel] = 1'b0;
    repeat (340) @(negedge clk);
    checkCounts(tag);
  endtask

  task automatic doBoth(input logic [7:0] st, input int res, input string tag);
    modelFull();
    modelEnd(st, res);
    @(negedge clk);
    statusIn[sel] = st;
    resCount[sel] = 5'(res);
    poolFull[sel] = 1'b1;
    msgEnd[sel] = 1'b1;
    @(negedge clk);
    poolFull[sel] = 1'b0;
    msgEnd[sel] = 1'b0;
    repeat (340) @(negedge clk);
    checkCounts(tag);
  endtask

  task automatic doOvf(input string tag);
    if (sel == 1) expRel[sel]++;
    @(negedge clk);
    fifoOvf[sel] = 1'b1;
    @(negedge clk);
    fifoOvf[sel] = 1'b0;
    repeat (10) @(negedge clk);
    checkCounts(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      statusIn[k] = 8'h00;
      resCount[k] = 5'd0;
      expRel[k] = 0;
      expRd[k] = 0;
      mCur[k] = 0;
    end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(fifoRd == 2'b00 && relCmd == 2'b00, "R11 reset strobes", {30'd0, fifoRd | relCmd}, 0);
    check(outValid == 2'b00 && outLast == 2'b00, "R11 reset output", {30'd0, outValid | outLast}, 0);

    // variant without trailer
    sel = 0;
    doEnd(8'h20, 5, "R2 short frame");
    doEnd(8'hAF, 0, "R2 R3 residual zero, spare bits ignored");
    doFull("R1 chunk one");
    doFull("R1 chunk two");
    doEnd(8'h20, 3, "R1 multi-chunk frame");
    doFull("R3 before reject");
    doEnd(8'h60, 4, "R3 overflow bit rejects");
    doEnd(8'h30, 4, "R3 abort bit rejects");
    doEnd(8'h00, 4, "R3 missing crc rejects");
    doEnd(8'h20, 2, "R3 buffer cleared after reject");
    for (int i = 0; i < 9; i++) doFull("R6 fill");
    doEnd(8'h20, 11, "R6 one below limit fits");
    for (int i = 0; i < 9; i++) doFull("R6 fill");
    doEnd(8'h20, 12, "R6 end chunk reaches limit");
    doEnd(8'h20, 1, "R7 index cleared after overrun");
    for (int i = 0; i < 9; i++) doFull("R6 fill");
    doFull("R6 pool chunk overruns");
    doEnd(8'h20, 5, "R6 only post-overrun bytes");
    doOvf("R8 overflow ignored without trailer");
    doBoth(8'h20, 4, "R10 simultaneous events ordered");

    // variant with trailer
    sel = 1;
    doEnd(8'hA0, 6, "R4 trailer stripped");
    doEnd(8'h20, 6, "R4 valid-frame bit required");
    doEnd(8'hA0, 1, "R7 zero length discarded");
    doFull("R8 before overflow");
    doOvf("R8 overflow releases only");
    doEnd(8'hA0, 2, "R8 buffer kept across overflow");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule